// File: doc/BRIEF.md
# Serial Word-Access Port for a 16x16 Shadow RAM

This block is the serial slave side of a small shadow RAM that holds sixteen 16-bit words. A host drives a serial clock `sk`, frames each transfer with an active-high `ce`, and shifts data in on `di`. Read data comes back on `sdo`, and `sdo_en` tells the pad when to drive it. Every frame starts with an 8-bit instruction. For a write, the 16-bit word follows on the same frame. For a read, the addressed word is streamed out. Four control instructions produce one-cycle pulses toward an external protection controller, which owns the write-enable and store policy. That controller feeds back `wr_allow` and `busy`.

The engine is a five-state machine clocked on the rising edge of `sk`:

- `ST_IDLE` waits for a start bit. Taken on a 1 on `di` with `ce` high, it moves to `ST_INSTR`.
- `ST_INSTR` gathers the address and opcode bits. On the eighth instruction bit it moves to `ST_WDATA`, to `ST_RDATA`, or to `ST_DONE`.
- `ST_WDATA` shifts in the data word.
- `ST_RDATA` rotates the read word out.
- `ST_DONE` waits out the rest of an ignored or finished frame.

From any state, `ce` sampled low returns the machine to `ST_IDLE`. That same edge commits a pending write.

The first read bit is launched by a flop on the falling edge of `sk`.

Top module: `shadow_ram_serial_port`

## Requirements
- R1: While `ce` is high, `di` is sampled on rising `sk`. Leading 0 bits are skipped. The first 1 is the start bit, then come a 4-bit address (MSB first) and a 3-bit opcode (MSB first).
- R2: Four opcodes each raise one pulse for exactly one `sk` cycle, starting at the edge that samples the eighth instruction bit: 000 raises `wen_clr_p`, 001 raises `store_p`, 100 raises `wen_set_p`, and 101 raises `recall_p`. At most one pulse is high at a time.
- R3: Opcode 011 with `wr_allow` high at the decode edge captures the following bits MSB first. The captured word is written to the addressed word on the first rising `sk` that sees `ce` low.
- R4: If a write frame ends with k<16 data bits, the written word holds those k bits in its low k positions and zeros above them. This includes k=0, which writes zero.
- R5: If a write frame carries more than 16 data bits, the last 16 bits received are written.
- R6: A write whose decode edge sees `wr_allow` low leaves the RAM unchanged.
- R7: Opcodes 110 and 111 both read, because the last instruction bit is ignored. `sdo_en` rises at the falling `sk` after the decode edge with `sdo` = bit 15. Each later rising `sk` advances `sdo` by one bit toward bit 0. After bit 0 the word repeats from bit 15.
- R8: `sdo_en` is low outside the read data phase, and it goes low as soon as `ce` goes low.
- R9: The following are ignored, meaning no pulse, no RAM change and no read output: opcode 010, and any instruction whose decode edge sees `busy` high.
- R10: Reset (`rst_n` low) puts the machine in `ST_IDLE`, sets all pulses and `sdo_en` low, and clears all RAM words to zero.
- R11: A frame abandoned by `ce` low before the instruction is complete has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Frame enable, active high |
| di | input | 1 | Serial data in |
| wr_allow | input | 1 | Write permission from the protection controller |
| busy | input | 1 | Store in progress; instructions are ignored |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | Drive enable for `sdo`; the pad floats when low |
| wen_set_p | output | 1 | Pulse: set write enable |
| wen_clr_p | output | 1 | Pulse: clear write enable |
| store_p | output | 1 | Pulse: request store |
| recall_p | output | 1 | Pulse: request recall |

## Verification
Timing of the results:

- A pulse is due one register after the edge that samples the eighth instruction bit.
- `sdo_en` and read bit 15 are due half a clock after that edge, from the falling-edge flop.
- Each further read bit is due one rising edge later.
- A write becomes visible at the edge where `ce` is first seen low, and it is observed through a later read frame.

The bench drives inputs 2 ns after each rising edge. It advances a behavioural model on every rising edge and compares all outputs 2 ns after each falling edge. That point lies after both the rising-edge and the falling-edge updates and before the next rising edge.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } port_state_t;

    localparam logic [2:0] OP_WDIS   = 3'b000;
    localparam logic [2:0] OP_STORE  = 3'b001;
    localparam logic [2:0] OP_RSVD   = 3'b010;
    localparam logic [2:0] OP_WRITE  = 3'b011;
    localparam logic [2:0] OP_WEN    = 3'b100;
    localparam logic [2:0] OP_RECALL = 3'b101;

    localparam int EV_CLR = 0;
    localparam int EV_STO = 1;
    localparam int EV_SET = 2;
    localparam int EV_RCL = 3;
    localparam int EV_N   = 4;
endpackage

// File: rtl/ssr_word_store.sv
module ssr_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ssr_read_shifter.sv
module ssr_read_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              sk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              shift,
    input  logic              arm,
    input  logic              ce,
    output logic              sdo,
    output logic              sdo_en
);
    logic [DATA_W-1:0] word_q;
    logic              oe_q;

    always_ff @(posedge sk or negedge rst_n) begin
        if (!rst_n)     word_q <= '0;
        else if (load)  word_q <= load_word;
        else if (shift) word_q <= {word_q[DATA_W-2:0], word_q[DATA_W-1]};
    end

    // first bit is launched half a clock after the decode edge
    always_ff @(negedge sk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= arm;
    end

    assign sdo    = oe_q & ce & word_q[DATA_W-1];
    assign sdo_en = oe_q & ce;
endmodule

// File: rtl/shadow_ram_serial_port.sv
module shadow_ram_serial_port
    import ssr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic sk,
    input  logic rst_n,
    input  logic ce,
    input  logic di,
    input  logic wr_allow,
    input  logic busy,
    output logic sdo,
    output logic sdo_en,
    output logic wen_set_p,
    output logic wen_clr_p,
    output logic store_p,
    output logic recall_p
);
    localparam int TAIL  = ADDR_W + 3;
    localparam int CNT_W = $clog2(TAIL + 1);

    port_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [TAIL-2:0]   sh_q, sh_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic [EV_N-1:0]   ev_q, ev_d;
    logic [TAIL-1:0]   full;
    logic [ADDR_W-1:0] dec_addr;
    logic [2:0]        dec_op;
    logic              ram_we, rd_load, rd_shift;
    logic [DATA_W-1:0] rd_word;

    assign full     = {sh_q, di};
    assign dec_addr = full[TAIL-1 -: ADDR_W];
    assign dec_op   = full[2:0];

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        sh_d     = sh_q;
        addr_d   = addr_q;
        data_d   = data_q;
        ev_d     = '0;
        ram_we   = 1'b0;
        rd_load  = 1'b0;
        rd_shift = 1'b0;
        if (!ce) begin
            state_d = ST_IDLE;
            ram_we  = (state_q == ST_WDATA);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (di) begin
                        state_d = ST_INSTR;
                        cnt_d   = '0;
                    end
                end
                ST_INSTR: begin
                    sh_d  = full[TAIL-2:0];
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(TAIL - 1)) begin
                        addr_d  = dec_addr;
                        state_d = ST_DONE;
                        if (!busy) begin
                            if (dec_op[2:1] == 2'b11) begin
                                state_d = ST_RDATA;
                                rd_load = 1'b1;
                            end else begin
                                case (dec_op)
                                    OP_WRITE: begin
                                        data_d = '0;
                                        if (wr_allow) state_d = ST_WDATA;
                                    end
                                    OP_WDIS:   ev_d[EV_CLR] = 1'b1;
                                    OP_STORE:  ev_d[EV_STO] = 1'b1;
                                    OP_WEN:    ev_d[EV_SET] = 1'b1;
                                    OP_RECALL: ev_d[EV_RCL] = 1'b1;
                                    default:   ;
                                endcase
                            end
                        end
                    end
                end
                ST_WDATA: data_d   = {data_q[DATA_W-2:0], di};
                ST_RDATA: rd_shift = 1'b1;
                ST_DONE:  ;
                default:  state_d  = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge sk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
        end
    end

    always_ff @(posedge sk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign wen_clr_p = ev_q[EV_CLR];
    assign store_p   = ev_q[EV_STO];
    assign wen_set_p = ev_q[EV_SET];
    assign recall_p  = ev_q[EV_RCL];

    ssr_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (sk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (dec_addr),
        .rdata (rd_word)
    );

    ssr_read_shifter #(.DATA_W(DATA_W)) u_rd (
        .sk        (sk),
        .rst_n     (rst_n),
        .load      (rd_load),
        .load_word (rd_word),
        .shift     (rd_shift),
        .arm       (state_q == ST_RDATA),
        .ce        (ce),
        .sdo       (sdo),
        .sdo_en    (sdo_en)
    );

    // R2
    pulse_onehot_chk: assert property (@(posedge sk) disable iff (!rst_n)
        $onehot0({wen_set_p, wen_clr_p, store_p, recall_p}));

    // R2
    pulse_single_chk: assert property (@(posedge sk) disable iff (!rst_n)
        (wen_set_p | wen_clr_p | store_p | recall_p)
        |=> !(wen_set_p | wen_clr_p | store_p | recall_p));

    // R8
    drive_in_read_chk: assert property (@(posedge sk) disable iff (!rst_n)
        sdo_en |-> (state_q == ST_RDATA));

    // R6
    write_entry_chk: assert property (@(posedge sk) disable iff (!rst_n)
        ((state_q == ST_WDATA) && ($past(state_q) != ST_WDATA))
        |-> ($past(wr_allow) && !$past(busy)));

    // R1
    instr_count_chk: assert property (@(posedge sk) disable iff (!rst_n)
        (state_q == ST_INSTR) |-> (cnt_q < CNT_W'(TAIL)));
endmodule

// File: tb/test_shadow_ram_serial_port.sv
module test_shadow_ram_serial_port;
    logic sk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, di = 1'b0, wr_allow = 1'b0, busy = 1'b0;
    logic sdo, sdo_en, wen_set_p, wen_clr_p, store_p, recall_p;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_req = "R10";

    shadow_ram_serial_port i_shadow_ram_serial_port (
        .sk(sk), .rst_n(rst_n), .ce(ce), .di(di), .wr_allow(wr_allow), .busy(busy),
        .sdo(sdo), .sdo_en(sdo_en), .wen_set_p(wen_set_p), .wen_clr_p(wen_clr_p),
        .store_p(store_p), .recall_p(recall_p)
    );

    always #4 sk = ~sk;

    // behavioural reference model
    int phase = 0;
    int ibits = 0, nb = 0;
    int mem [16];
    int waddr = 0, wdata = 0, rword = 0, ridx = 0;
    bit e_set = 0, e_clr = 0, e_sto = 0, e_rcl = 0;

    initial for (int i = 0; i < 16; i++) mem[i] = 0;

    always @(posedge sk or negedge rst_n) begin
        if (!rst_n) begin
            phase = 0;
            for (int i = 0; i < 16; i++) mem[i] = 0;
            {e_set, e_clr, e_sto, e_rcl} = 4'b0;
        end else begin
            {e_set, e_clr, e_sto, e_rcl} = 4'b0;
            if (!ce) begin
                if (phase == 2) mem[waddr] = wdata;
                phase = 0;
            end else begin
                case (phase)
                    0: if (di) begin phase = 1; ibits = 1; nb = 0; end
                    1: begin
                        ibits = ibits * 2 + int'(di);
                        nb++;
                        if (nb == 7) begin
                            int a, op;
                            a = (ibits >> 3) & 15;
                            op = ibits & 7;
                            phase = 4;
                            if (!busy) begin
                                if (op >= 6) begin phase = 3; rword = mem[a]; ridx = 0; end
                                else if (op == 3) begin
                                    wdata = 0;
                                    waddr = a;
                                    if (wr_allow) phase = 2;
                                end
                                else if (op == 0) e_clr = 1;
                                else if (op == 1) e_sto = 1;
                                else if (op == 4) e_set = 1;
                                else if (op == 5) e_rcl = 1;
                            end
                        end
                    end
                    2: wdata = ((wdata << 1) | int'(di)) & 16'hFFFF;
                    3: ridx++;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    // compare every clock, after both edges have settled
    always @(negedge sk) begin
        #2;
        begin
            bit exp_en, exp_bit;
            exp_en = (phase == 3) && ce;
            exp_bit = rword[15 - (ridx % 16)];
            check(sdo_en == exp_en, "sdo_en", int'(sdo_en), int'(exp_en));
            if (exp_en) check(sdo == exp_bit, "sdo", int'(sdo), int'(exp_bit));
            check({wen_set_p, wen_clr_p, store_p, recall_p} == {e_set, e_clr, e_sto, e_rcl},
                  "pulses", int'({wen_set_p, wen_clr_p, store_p, recall_p}),
                  int'({e_set, e_clr, e_sto, e_rcl}));
        end
    end

    task automatic tick(input logic c, input logic d);
        @(posedge sk);
        #2;
        ce = c;
        di = d;
    endtask

    task automatic frame(input logic [7:0] ins, input logic [15:0] dat, input int nd);
        for (int i = 7; i >= 0; i--) tick(1'b1, ins[i]);
        for (int j = 0; j < nd; j++) tick(1'b1, dat[15 - (j % 16)]);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    function automatic logic [7:0] ins(input int a, input int op);
        return {1'b1, 4'(a), 3'(op)};
    endfunction

    initial begin
        repeat (3) @(posedge sk);
        #2;
        // R10: reset state at the ports
        check(sdo_en == 1'b0, "R10 sdo_en in reset", int'(sdo_en), 0);
        check({wen_set_p, wen_clr_p, store_p, recall_p} == 4'b0, "R10 pulses in reset",
              int'({wen_set_p, wen_clr_p, store_p, recall_p}), 0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0);
        frame(ins(9, 6), 16'h0, 18);             // R10: RAM reads zero after reset

        cur_req = "R3";  wr_allow = 1'b1;
        frame(ins(3, 3), 16'hA5C3, 16);
        cur_req = "R7";
        frame(ins(3, 6), 16'h0, 20);             // R7: I0 = 0, wraps
        frame(ins(3, 7), 16'h0, 16);             // R7: I0 = 1

        cur_req = "R2";
        frame(ins(0, 4), 16'h0, 0);
        frame(ins(7, 0), 16'h0, 0);
        frame(ins(2, 1), 16'h0, 0);
        frame(ins(15, 5), 16'h0, 0);

        cur_req = "R4";
        frame(ins(5, 3), 16'hB000, 5);           // 10110 -> 0016
        frame(ins(5, 6), 16'h0, 16);
        frame(ins(8, 3), 16'hFFFF, 0);
        frame(ins(8, 6), 16'h0, 16);

        cur_req = "R5";
        frame(ins(6, 3), 16'h1234, 20);
        frame(ins(6, 6), 16'h0, 16);

        cur_req = "R6"; wr_allow = 1'b0;
        frame(ins(3, 3), 16'h5555, 16);
        frame(ins(3, 6), 16'h0, 16);
        wr_allow = 1'b1;

        cur_req = "R9";
        frame(ins(3, 2), 16'h0, 8);
        busy = 1'b1;
        frame(ins(3, 3), 16'hFFFF, 16);
        frame(ins(3, 6), 16'h0, 8);
        frame(ins(0, 4), 16'h0, 0);
        busy = 1'b0;
        frame(ins(3, 6), 16'h0, 16);

        cur_req = "R11";
        tick(1'b1, 1'b1); tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b1);
        tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        frame(ins(3, 6), 16'h0, 16);

        cur_req = "R8";                          // CE drop mid-read
        frame(ins(5, 6), 16'h0, 5);

        cur_req = "R1";                          // leading zeros skipped
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        frame(ins(10, 3), 16'hC0DE, 16);
        frame(ins(10, 7), 16'h0, 16);

        repeat (3) @(posedge sk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    always @(posedge sk) begin
        cycles++;
        if (cycles >= 200000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp<%0d", cycles, 200000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule